// File: doc/BRIEF.md
# Dual-Channel Operating-System Timer

This block is a bus-attached timer with two independent channels behind a 32-bit register port with word addresses. The first channel is a one-shot event timer. Once started, it counts prescaled ticks up to a programmed compare value. It then raises a flag, which drives an interrupt line unless a mask bit is set, and it holds its count until software clears or stops it. The second channel is a free-running 64-bit time base. Software reads it as a low word and a buffered high word.

Each channel has its own prescaler with a power-of-four divide code, its own counter-clear bit and its own run state. Software starts a channel through a write-one-to-set register and stops it through a write-one-to-clear register. Reads are registered: read data appears on the clock edge that samples `rd_en`.

Top module: `dual_os_timer`

## Requirements
- R1: After reset, both channels are stopped, the interrupt line is low, and every register reads zero, including the divide field at 0x00.
- R2: The divide field at 0x00 takes bits [1:0] for the event channel and bits [3:2] for the time base. Code 0 divides by 1, code 1 by 4 and code 2 (or 3) by 16.
- R3: Writing 1 to bit 0 at offset 0x08 zeroes the event count. Writing 1 to bit 1 zeroes the time base. The register reads as zero.
- R4: Writing 1 to bit n at offset 0x34 starts channel n+1, and writing 1 to bit n at offset 0x38 stops it. Bits written as 0 leave that channel's state unchanged. Both offsets read back the run state in bits [1:0].
- R5: A running event channel with divide 1 and compare value C (any value from 4 upward) sets flag bit 0 at offset 0x0C exactly C clock cycles after the start write. With divide 4 it sets the flag 4*C cycles after the start write.
- R6: After the match, the event count at offset 0x18 holds at C and the flag is not raised again.
- R7: Writing 0 to flag bit 0 clears the flag. Writing 1 to it has no effect.
- R8: Bit 0 at offset 0x10 masks the interrupt. The irq output equals flag AND NOT mask.
- R9: Stopping the event channel freezes its count. Writes to the read-only count offsets have no effect.
- R10: The time base counts prescaled ticks while running and wraps with no interrupt. A read of offset 0x20 returns the low word and copies the high word into the buffer that offset 0x24 returns.
- R11: Unmapped offsets read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset, word aligned |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Event-channel interrupt |

## Verification
The hardest case to reach is the exact cycle of the match under a prescaler. That cycle depends on when the divider phase restarts relative to the start write. The stimulus aligns each bus access to the falling edge and clears the channel before starting it. It then counts clock cycles from the start write and samples irq one cycle before and one cycle at the expected match, for both divide 1 and divide 4. The time-base capture is reached by reading the low word after a known number of cycles and then reading the high buffer.

// File: rtl/dual_os_timer.sv
module dual_os_timer #(
  parameter int DW = 32,
  parameter int AW = 8,
  parameter int TB_W = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam logic [AW-1:0] A_DIV  = 'h00, A_CLR = 'h08, A_FLAG = 'h0C, A_MASK = 'h10,
                            A_CMP  = 'h14, A_EV  = 'h18, A_TBL  = 'h20, A_TBH  = 'h24,
                            A_RUNS = 'h34, A_RUNC = 'h38;

  logic [3:0]      div_sel;
  logic [1:0]      run;
  logic            flag, mask;
  logic [DW-1:0]   cmp, ev_cnt;
  logic [TB_W-1:0] tb_cnt;
  logic [DW-1:0]   hi_buf;
  logic [3:0]      pcnt [2];
  logic [1:0]      tick, clr;

  wire wr_div  = wr_en && addr == A_DIV;
  wire wr_flag = wr_en && addr == A_FLAG;
  wire wr_mask = wr_en && addr == A_MASK;
  wire wr_cmp  = wr_en && addr == A_CMP;
  wire wr_runs = wr_en && addr == A_RUNS;
  wire wr_runc = wr_en && addr == A_RUNC;
  assign clr   = (wr_en && addr == A_CLR) ? wdata[1:0] : 2'b00;

  function automatic logic [3:0] div_lim(input logic [1:0] code);
    return (code == 2'd0) ? 4'd0 : (code == 2'd1) ? 4'd3 : 4'd15;
  endfunction

  for (genvar i = 0; i < 2; i++) begin : g_pre
    assign tick[i] = run[i] && pcnt[i] == div_lim(div_sel[2*i +: 2]);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                        pcnt[i] <= '0;
      else if (!run[i] || clr[i] || tick[i]) pcnt[i] <= '0;
      else                               pcnt[i] <= pcnt[i] + 4'd1;
  end

  wire ev_step  = run[0] && tick[0] && !clr[0] && ev_cnt != cmp;
  wire ev_match = ev_step && (ev_cnt + 1'b1) == cmp;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_sel <= '0;
      run     <= '0;
      mask    <= 1'b0;
      cmp     <= '0;
      flag    <= 1'b0;
    end else begin
      if (wr_div)  div_sel <= wdata[3:0];
      if (wr_mask) mask    <= wdata[0];
      if (wr_cmp)  cmp     <= wdata;
      run <= (run | (wr_runs ? wdata[1:0] : 2'b00)) & ~(wr_runc ? wdata[1:0] : 2'b00);
      if (ev_match)                   flag <= 1'b1;
      else if (wr_flag && !wdata[0])  flag <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       ev_cnt <= '0;
    else if (clr[0])  ev_cnt <= '0;
    else if (ev_step) ev_cnt <= ev_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   tb_cnt <= '0;
    else if (clr[1])              tb_cnt <= '0;
    else if (run[1] && tick[1])   tb_cnt <= tb_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rdata  <= '0;
      hi_buf <= '0;
    end else if (rd_en) begin
      case (addr)
        A_DIV:          rdata <= DW'(div_sel);
        A_FLAG:         rdata <= DW'(flag);
        A_MASK:         rdata <= DW'(mask);
        A_CMP:          rdata <= cmp;
        A_EV:           rdata <= ev_cnt;
        A_TBL: begin
          rdata  <= tb_cnt[DW-1:0];
          hi_buf <= tb_cnt[TB_W-1:DW];
        end
        A_TBH:          rdata <= hi_buf;
        A_RUNS, A_RUNC: rdata <= DW'(run);
        default:        rdata <= '0;
      endcase
    end

  assign irq = flag & ~mask;
endmodule

// File: rtl/dual_os_timer_chk.sv
module dual_os_timer_chk #(
  parameter int DW = 32,
  parameter int TB_W = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq,
  input logic            flag,
  input logic            mask,
  input logic [1:0]      run,
  input logic [1:0]      clr,
  input logic [DW-1:0]   cmp,
  input logic [DW-1:0]   ev_cnt,
  input logic [TB_W-1:0] tb_cnt
);
  // R5
  flag_at_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> ev_cnt == $past(cmp));

  // R8
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask |-> !irq);

  // R6
  hold_at_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cnt == cmp && !clr[0]) |=> ev_cnt == $past(ev_cnt));

  // R9
  ev_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run[0] && !clr[0]) |=> $stable(ev_cnt));

  // R10
  tb_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr[1] |=> (tb_cnt - $past(tb_cnt)) <= TB_W'(1));
endmodule

bind dual_os_timer dual_os_timer_chk #(.DW(DW), .TB_W(TB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .flag(flag), .mask(mask), .run(run),
  .clr(clr), .cmp(cmp), .ev_cnt(ev_cnt), .tb_cnt(tb_cnt)
);

// File: tb/dual_os_timer_tb.sv
module dual_os_timer_tb;
  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  dual_os_timer u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
                       .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq", 32'(irq), 0);
    rd(8'h00, d); chk("R1 div", d, 0);
    rd(8'h34, d); chk("R1 run", d, 0);
    rd(8'h0C, d); chk("R1 flag", d, 0);
    rd(8'h24, d); chk("R1 hibuf", d, 0);
  endtask

  task automatic t_oneshot_div1;
    logic [31:0] d;
    wr(8'h14, 4); wr(8'h08, 1); wr(8'h34, 1);
    repeat (3) @(negedge clk);
    chk("R5 div1 early", 32'(irq), 0);
    @(negedge clk);
    chk("R5 div1 match", 32'(irq), 1);
    repeat (5) @(negedge clk);
    rd(8'h18, d); chk("R6 hold", d, 4);
    wr(8'h0C, 1); chk("R7 write1 keeps", 32'(irq), 1);
    wr(8'h0C, 0); chk("R7 clear", 32'(irq), 0);
    repeat (5) @(negedge clk);
    chk("R6 no refire", 32'(irq), 0);
    wr(8'h38, 1);
  endtask

  task automatic t_oneshot_div4_mask;
    logic [31:0] d;
    wr(8'h00, 1); rd(8'h00, d); chk("R2 div field", d, 1);
    wr(8'h10, 1);
    wr(8'h14, 5); wr(8'h08, 1); wr(8'h34, 1);
    repeat (19) @(negedge clk);
    rd(8'h0C, d); chk("R5 div4 early", d, 0);
    rd(8'h0C, d); chk("R5 div4 match", d, 1);
    chk("R8 masked", 32'(irq), 0);
    wr(8'h10, 0); chk("R8 unmasked", 32'(irq), 1);
    wr(8'h0C, 0); wr(8'h38, 1); wr(8'h00, 0);
  endtask

  task automatic t_stop_hold;
    logic [31:0] d;
    wr(8'h14, 100); wr(8'h08, 1); wr(8'h34, 1);
    repeat (10) @(negedge clk);
    wr(8'h38, 1);
    repeat (5) @(negedge clk);
    rd(8'h18, d); chk("R9 frozen", d, 11);
    wr(8'h18, 32'h55); rd(8'h18, d); chk("R9 ro", d, 11);
    wr(8'h08, 1); rd(8'h18, d); chk("R3 ev clear", d, 0);
    rd(8'h08, d); chk("R3 reads zero", d, 0);
  endtask

  task automatic t_timebase;
    logic [31:0] d;
    wr(8'h08, 2); wr(8'h34, 2);
    repeat (10) @(negedge clk);
    rd(8'h20, d); chk("R10 low div1", d, 10);
    rd(8'h24, d); chk("R10 high buf", d, 0);
    wr(8'h34, 1); wr(8'h38, 0);
    rd(8'h34, d); chk("R4 zero bits ignored", d, 3);
    wr(8'h38, 1); rd(8'h38, d); chk("R4 clear ch1", d, 2);
    wr(8'h38, 2); wr(8'h00, 32'h8); wr(8'h08, 2); wr(8'h34, 2);
    repeat (40) @(negedge clk);
    rd(8'h20, d); chk("R2 div16 tb", d, 2);
    wr(8'h38, 2); wr(8'h08, 2); wr(8'h00, 0);
    rd(8'h20, d); chk("R3 tb clear", d, 0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    wr(8'h40, 32'hFFFF_FFFF); wr(8'h04, 32'hF);
    rd(8'h40, d); chk("R11 read zero", d, 0);
    rd(8'h00, d); chk("R11 div kept", d, 0);
    rd(8'h34, d); chk("R11 run kept", d, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_oneshot_div1;
        t_oneshot_div4_mask;
        t_stop_hold;
        t_timebase;
        t_unmapped;
      end
      begin
        repeat (20000) @(negedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule